// File: doc/BRIEF.md
# Open-Drain Data Line Direction Arbiter

This block joins a host-side open-drain data line to a card-side open-drain data line and decides on its own which way data flows. No direction pin is used. Both line levels are sampled on a fast clock. When the block is idle, the line that falls first becomes the input, and the block pulls the other line low so that it follows. When the input line rises again, the block releases the drive. It then waits a holdoff window before it accepts a new falling edge. A chip needs one instance for each data line: the main data line and the two auxiliary lines.

The block has two control inputs. The reception enable comes from the power sequencer. While it is low, the card line is held low and the host line is left to idle high. The chip-select enable decides whether the host side may be driven at all. While it is low, no level passes in either direction and the block stays idle. Edge-rate shaping and analog propagation delays are not modelled. The sampling clock is assumed to run much faster than the 1 MHz maximum data rate.

Top module: `iodir_arbiter`

## Requirements
- R1: While `rx_en` is low, one clock after it is sampled low, `card_pull` is 1, `host_pull` is 0 and `busy` is 1, whatever the line levels do. This is also the state out of reset.
- R2: When `rx_en` is high and the block leaves the disabled state, it reaches the idle state on the next clock. In the idle state `host_pull` and `card_pull` are both 0.
- R3: In the idle state, a falling edge on one line makes that line the input. The block then drives the opposite line low: `card_pull`=1 when the host line fell, and `host_pull`=1 when the card line fell. Both pulls are never 1 at the same time.
- R4: A rising edge on the input line releases the pull on the other line, and the block enters the holdoff state with `busy` still 1.
- R5: While `cs_en` is low, `host_pull` is 0 from the next clock on, the block sits idle, and no falling edge on either line causes a drive.
- R6: If both lines are seen falling in the same cycle while idle, the host line becomes the input (`card_pull`=1, `host_pull`=0).
- R7: Falling edges that occur during holdoff are discarded. A line that is still low when holdoff ends does not start a transfer, because only edges trigger one.
- R8: The holdoff state lasts exactly `HOLDOFF_CYCLES` clocks when that value is at least 1 (one clock when it is 0), and the block then returns to idle.
- R9: `busy` is 0 exactly when the block is in the idle state.
- R10: A falling edge on a line input appears on the opposite pull output `SYNC_STAGES`+1 clocks after the input changes, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_in | input | 1 | Sampled level of the host-side line |
| card_in | input | 1 | Sampled level of the card-side line |
| rx_en | input | 1 | Reception enable from the sequencer |
| cs_en | input | 1 | Chip-select enable for the host side |
| host_pull | output | 1 | 1 pulls the host-side line low |
| card_pull | output | 1 | 1 pulls the card-side line low |
| busy | output | 1 | High whenever the block is not idle |

## Verification
The bench builds the block with `SYNC_STAGES`=2 and `HOLDOFF_CYCLES`=6, and models each line as a wired-AND of the external pull and the block's own pull.

Two synchronizer stages give a three-clock latency. This leaves a visible cycle in which the edge has been applied but no drive should appear yet, so an off-by-one in the sampling path is caught.

A six-clock holdoff is long enough for the bench to place a full card-side falling edge inside the window and let that edge clear the synchronizer before the window closes. This exercises the rule that an edge discarded during holdoff stays discarded. It also separates the end of holdoff from the edge's own detection by several clocks.

// File: rtl/iodir_pkg.sv
package iodir_pkg;

   // Arbiter states; ARB_IDLE is the neutral state.
   typedef enum logic [2:0] {
      ARB_OFF  = 3'd0,
      ARB_IDLE = 3'd1,
      ARB_HOST = 3'd2,
      ARB_CARD = 3'd3,
      ARB_HOLD = 3'd4
   } arb_state_t;

   // Line index inside the sampled-line vector
   localparam int HOST_IDX = 0;
   localparam int CARD_IDX = 1;
   localparam int NLINES   = 2;

endpackage

// File: rtl/iodir_edge.sv
module iodir_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic fall_o,
   output logic rise_o
);

   logic cur;
   logic prev;

   generate
      if (SYNC_STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) cur <= 1'b1;
            else        cur <= line_i;
         end
      end else begin : g_chain
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[SYNC_STAGES-2:0], line_i};
         end
         assign cur = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b1;
      else        prev <= cur;
   end

   assign fall_o = prev & ~cur;
   assign rise_o = ~prev & cur;

endmodule

// File: rtl/iodir_holdoff.sv
module iodir_holdoff #(
   parameter int HOLDOFF_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic done_o
);

   localparam int CW = (HOLDOFF_CYCLES > 1) ? $clog2(HOLDOFF_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'((HOLDOFF_CYCLES > 0) ? HOLDOFF_CYCLES - 1 : 0);

   generate
      if (HOLDOFF_CYCLES == 0) begin : g_none
         logic unused_run;
         assign unused_run = run_i;
         assign done_o     = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt;
         always_ff @(posedge clk) begin
            if (!rst_n || !run_i) cnt <= '0;
            else if (cnt != LAST) cnt <= cnt + 1'b1;
         end
         assign done_o = (cnt == LAST);
      end
   endgenerate

endmodule

// File: rtl/iodir_fsm.sv
module iodir_fsm
   import iodir_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_en,
   input  logic       cs_en,
   input  logic       host_fall,
   input  logic       host_rise,
   input  logic       card_fall,
   input  logic       card_rise,
   input  logic       hold_done,
   output arb_state_t state_o
);

   arb_state_t st;
   arb_state_t nxt;

   always_comb begin
      nxt = st;
      if (!rx_en) begin
         nxt = ARB_OFF;
      end else if (!cs_en) begin
         nxt = ARB_IDLE;
      end else begin
         case (st)
            ARB_OFF:  nxt = ARB_IDLE;
            ARB_IDLE: begin
               if (host_fall)      nxt = ARB_HOST;
               else if (card_fall) nxt = ARB_CARD;
            end
            ARB_HOST: if (host_rise) nxt = ARB_HOLD;
            ARB_CARD: if (card_rise) nxt = ARB_HOLD;
            ARB_HOLD: if (hold_done) nxt = ARB_IDLE;
            default:  nxt = ARB_OFF;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ARB_OFF;
      else        st <= nxt;
   end

   assign state_o = st;

endmodule

// File: rtl/iodir_arbiter.sv
module iodir_arbiter
   import iodir_pkg::*;
#(
   parameter int SYNC_STAGES    = 2,
   parameter int HOLDOFF_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic host_in,
   input  logic card_in,
   input  logic rx_en,
   input  logic cs_en,
   output logic host_pull,
   output logic card_pull,
   output logic busy
);

   generate
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 1..4");
      end
      if (HOLDOFF_CYCLES < 0) begin : g_bad_hold
         $error("HOLDOFF_CYCLES must not be negative");
      end
   endgenerate

   logic [NLINES-1:0] raw;
   logic [NLINES-1:0] falls;
   logic [NLINES-1:0] rises;
   logic              hold_done;
   arb_state_t        state;

   assign raw[HOST_IDX] = host_in;
   assign raw[CARD_IDX] = card_in;

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      iodir_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (raw[g]),
         .fall_o (falls[g]),
         .rise_o (rises[g])
      );
   end

   iodir_holdoff #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (state == ARB_HOLD),
      .done_o (hold_done)
   );

   iodir_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_en     (rx_en),
      .cs_en     (cs_en),
      .host_fall (falls[HOST_IDX]),
      .host_rise (rises[HOST_IDX]),
      .card_fall (falls[CARD_IDX]),
      .card_rise (rises[CARD_IDX]),
      .hold_done (hold_done),
      .state_o   (state)
   );

   assign host_pull = (state == ARB_CARD);
   assign card_pull = (state == ARB_OFF) || (state == ARB_HOST);
   assign busy      = (state != ARB_IDLE);

endmodule

// File: rtl/iodir_arbiter_chk.sv
module iodir_arbiter_chk (
   input logic clk,
   input logic rst_n,
   input logic rx_en,
   input logic cs_en,
   input logic host_pull,
   input logic card_pull,
   input logic busy
);

   // R1
   rx_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (card_pull && !host_pull && busy));

   // R5
   cs_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_en |=> !host_pull);

   // R3
   one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_pull && card_pull));

   // R9
   idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!host_pull && !card_pull));

   // R4
   release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(host_pull) && $past(rx_en) && $past(cs_en)) |-> busy);

endmodule

bind iodir_arbiter iodir_arbiter_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_en     (rx_en),
   .cs_en     (cs_en),
   .host_pull (host_pull),
   .card_pull (card_pull),
   .busy      (busy)
);

// File: tb/iodir_arbiter_test.sv
`timescale 1ns/1ps
module iodir_arbiter_test;

   localparam int SYNC = 2;
   localparam int HOLD = 6;
   localparam int LAT  = SYNC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_en = 1'b0;
   logic cs_en = 1'b0;
   logic h_ext = 1'b0;
   logic c_ext = 1'b0;
   logic host_in, card_in;
   logic host_pull, card_pull, busy;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [2:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   // wired-AND open-drain lines
   assign host_in = ~(h_ext | host_pull);
   assign card_in = ~(c_ext | card_pull);

   iodir_arbiter #(.SYNC_STAGES(SYNC), .HOLDOFF_CYCLES(HOLD)) uut (
      .clk(clk), .rst_n(rst_n), .host_in(host_in), .card_in(card_in),
      .rx_en(rx_en), .cs_en(cs_en),
      .host_pull(host_pull), .card_pull(card_pull), .busy(busy)
   );

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(posedge clk);
   endtask

   // expected {host_pull, card_pull, busy}, sampled at the next falling edge
   task automatic expect_out(input logic hp, input logic cp, input logic bz, input string tag);
      exp_q.push_back({hp, cp, bz});
      tag_q.push_back(tag);
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            logic [2:0] e;
            logic [2:0] a;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {host_pull, card_pull, busy};
            checks++;
            if (a !== e) begin
               errors++;
               $display("FAIL %s: {host_pull,card_pull,busy} actual %b expected %b", t, a, e);
            end
         end
      end
   end

   // watchdog
   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      tick(3);
      expect_out(0, 1, 1, "R1 reset state");
      tick(1); #1 rst_n = 1'b1;
      tick(2);
      expect_out(0, 1, 1, "R1 rx disabled");

      #1 rx_en = 1'b1; cs_en = 1'b1;
      tick(1);
      expect_out(0, 0, 0, "R2 neutral after enable");
      tick(4);
      expect_out(0, 0, 0, "R9 idle not busy");

      // host to card
      #1 h_ext = 1'b1;
      tick(LAT - 1);
      expect_out(0, 0, 0, "R10 no drive before latency");
      tick(1);
      expect_out(0, 1, 1, "R3 host fall drives card");
      tick(3);
      #1 h_ext = 1'b0;
      tick(LAT);
      expect_out(0, 0, 1, "R4 release into holdoff");
      tick(HOLD - 1);
      expect_out(0, 0, 1, "R8 still in holdoff");
      tick(1);
      expect_out(0, 0, 0, "R8 holdoff ends");
      tick(3);

      // card to host
      #1 c_ext = 1'b1;
      tick(LAT);
      expect_out(1, 0, 1, "R3 card fall drives host");
      tick(2);
      #1 c_ext = 1'b0;
      tick(LAT);
      expect_out(0, 0, 1, "R4 card release");
      tick(HOLD + 2);
      expect_out(0, 0, 0, "R8 back to neutral");

      // simultaneous falls
      #1 h_ext = 1'b1; c_ext = 1'b1;
      tick(LAT);
      expect_out(0, 1, 1, "R6 host wins tie");
      tick(2);
      #1 h_ext = 1'b0; c_ext = 1'b0;
      tick(LAT);
      expect_out(0, 0, 1, "R6 tie release");
      tick(HOLD + 3);
      expect_out(0, 0, 0, "R6 tie settled");

      // fall inside holdoff is discarded
      #1 h_ext = 1'b1;
      tick(LAT + 2);
      #1 h_ext = 1'b0;
      tick(LAT);
      expect_out(0, 0, 1, "R7 in holdoff");
      tick(1);
      #1 c_ext = 1'b1;
      tick(HOLD + 1);
      expect_out(0, 0, 0, "R7 fall during holdoff ignored");
      tick(4);
      expect_out(0, 0, 0, "R7 low level does not trigger");
      #1 c_ext = 1'b0;
      tick(5);

      // chip select low
      #1 c_ext = 1'b1;
      tick(LAT);
      expect_out(1, 0, 1, "R3 card drives host again");
      #1 cs_en = 1'b0;
      tick(1);
      expect_out(0, 0, 0, "R5 cs low stops host drive");
      #1 h_ext = 1'b1;
      tick(LAT + 1);
      expect_out(0, 0, 0, "R5 no transfer with cs low");
      #1 h_ext = 1'b0; c_ext = 1'b0;
      tick(5);
      #1 cs_en = 1'b1;
      tick(4);
      expect_out(0, 0, 0, "R5 cs restored idle");

      // reception disabled during a transfer
      #1 c_ext = 1'b1;
      tick(LAT);
      expect_out(1, 0, 1, "R3 card drives host before disable");
      #1 rx_en = 1'b0;
      tick(1);
      expect_out(0, 1, 1, "R1 disable holds card low");
      #1 h_ext = 1'b1;
      tick(LAT + 1);
      expect_out(0, 1, 1, "R1 host fall ignored while disabled");
      #1 h_ext = 1'b0; c_ext = 1'b0;
      tick(5);
      #1 rx_en = 1'b1;
      tick(1);
      expect_out(0, 0, 0, "R2 re-enable to neutral");
      tick(4);
      expect_out(0, 0, 0, "R9 idle after re-enable");

      tick(3);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule